// File: doc/BRIEF.md
# Memory Sleep-State Sequencer

This block runs the power-down handshake of a synchronous memory. A sleep request arrives on a pin with no timing relation to the clock. The block synchronizes that pin and steps a small state machine through a fixed entry phase, the sleep state itself, a fixed exit phase and a post-wake recovery window. Its flags let the surrounding array and I/O logic hold still. Stored contents are never touched while the block is busy, because no selection reaches the array in that time.

The chip-select lines pass through the block. A command reaches the array only when every select is active and the sequencer is fully awake. An access that is still outstanding when entry begins is given up, and the block reports this with a one-cycle abort pulse. Selecting the memory at any time while the sequencer is busy is a protocol breach. The block ignores such a command and latches a sticky error flag, which only reset clears.

Top module: `mem_sleep_seq`

## Requirements
- R1: While reset is active and right after it is released, sleep_o, busy_o, abort_o and err_o are all 0.
- R2: The request pin passes through two synchronizing flops. If sleep_req_i is high at rising edge E0 and stays high, busy_o is 1 after edge E2, and sleep_o is still 0 then.
- R3: Entry lasts exactly two cycles, during which busy_o=1 and sleep_o=0. With the request held from E0, sleep_o is 1 after edge E4 and stays 1 while the request stays high.
- R4: If sleep_req_i goes low at edge E0 while asleep, sleep_o stays 1 through two exit cycles and is 0 after edge E4. Two recovery cycles follow, with busy_o=1 and sleep_o=0, and busy_o is 0 after edge E6.
- R5: cmd_o is 1 only when all NUM_SEL bits of sel_i are 1 and busy_o is 0. While busy_o is 1, cmd_o is 0 whatever sel_i holds.
- R6: If all selects are active in a cycle with busy_o=1, err_o is 1 from the next edge on and stays 1 until reset. Selections made while busy_o=0 never set it.
- R7: If acc_pend_i is high at the edge where entry begins, abort_o is 1 for exactly the first entry cycle. If acc_pend_i is low at that edge, abort_o stays 0.
- R8: Once entry has begun it runs to completion, even if the request drops. The block then spends at least one cycle asleep before it starts the exit phase.
- R9: If the request is reasserted during exit or recovery, the block first finishes recovery. It then spends one awake cycle and begins a new entry on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Asynchronous sleep request, high to sleep |
| sel_i | input | NUM_SEL | Chip selects, active high; the memory is selected when all are 1 |
| acc_pend_i | input | 1 | An access is outstanding in the memory pipeline |
| cmd_o | output | 1 | Selection forwarded to the array |
| sleep_o | output | 1 | Array and I/O held in sleep |
| busy_o | output | 1 | Sequencer not fully awake |
| abort_o | output | 1 | Pulse: outstanding access discarded at sleep entry |
| err_o | output | 1 | Sticky: selection attempted while busy |

## Verification
The interesting collision is a selection that lands in the same cycle as a state transition of the sequencer. Examples are the last awake cycle before entry, the first recovery cycle, or the single awake cycle between recovery and a re-entry. The bench replays one complete sleep cycle many times from reset and moves a one-cycle full selection across every cycle offset of it. At each offset it judges cmd_o in that cycle and err_o on the next edge against a busy window computed from the pin-to-flag latencies. Separate runs place a short request pulse inside entry and a reassertion inside recovery, and check the aborted-access pulse against the edge where entry starts.

// File: rtl/mss_pkg.sv
`timescale 1ns/1ps
package mss_pkg;

  // Sequencer phases; order carries no meaning outside the FSM.
  typedef enum logic [2:0] {
    ST_AWAKE  = 3'd0,
    ST_ENTER  = 3'd1,
    ST_ASLEEP = 3'd2,
    ST_EXIT   = 3'd3,
    ST_RECOV  = 3'd4
  } mss_state_e;

endpackage

// File: rtl/mss_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a level that is asynchronous to clk_i.
module mss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = async_i;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/mss_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: fixed-length entry, exit and recovery phases.
module mss_fsm
  import mss_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_s_i,
  output mss_state_e state_o,
  output logic       enter_start_o
);

  localparam int MAX_AB  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int MAX_CYC = (MAX_AB > RECOV_CYC) ? MAX_AB : RECOV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] ENT_LAST = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(EXIT_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(RECOV_CYC - 1);

  mss_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  // Next-state and phase counter.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_AWAKE: begin
        cnt_d = '0;
        if (req_s_i) state_d = ST_ENTER;
      end
      ST_ENTER: begin
        if (cnt_q == ENT_LAST) begin
          state_d = ST_ASLEEP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ASLEEP: begin
        cnt_d = '0;
        if (!req_s_i) state_d = ST_EXIT;
      end
      ST_EXIT: begin
        if (cnt_q == EXT_LAST) begin
          state_d = ST_RECOV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q == REC_LAST) begin
          state_d = ST_AWAKE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  assign upd_en = (state_d != state_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      cnt_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o       = state_q;
  assign enter_start_o = (state_q == ST_AWAKE) && req_s_i;

endmodule

// File: rtl/mss_guard.sv
`timescale 1ns/1ps
// Select gating, protocol-error latch and abort pulse.
module mss_guard
  import mss_pkg::*;
#(
  parameter int NUM_SEL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  mss_state_e         state_i,
  input  logic               enter_start_i,
  input  logic [NUM_SEL-1:0] sel_i,
  input  logic               acc_pend_i,
  output logic               cmd_o,
  output logic               sleep_o,
  output logic               busy_o,
  output logic               abort_o,
  output logic               err_o
);

  logic sel_all;
  logic busy;
  logic err_q, err_d, err_en;
  logic abort_q, abort_d;

  assign sel_all = &sel_i;
  assign busy    = (state_i != ST_AWAKE);

  assign err_d   = 1'b1;
  assign err_en  = busy && sel_all && !err_q;
  assign abort_d = enter_start_i && acc_pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_q <= 1'b0;
    end else begin
      abort_q <= abort_d;
    end
  end

  assign cmd_o   = sel_all && !busy;
  assign sleep_o = (state_i == ST_ASLEEP) || (state_i == ST_EXIT);
  assign busy_o  = busy;
  assign abort_o = abort_q;
  assign err_o   = err_q;

endmodule

// File: rtl/mem_sleep_seq.sv
`timescale 1ns/1ps
// Top: sleep-state sequencer for a synchronous memory.
module mem_sleep_seq
  import mss_pkg::*;
#(
  parameter int NUM_SEL     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int RECOV_CYC   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_req_i,
  input  logic [NUM_SEL-1:0] sel_i,
  input  logic               acc_pend_i,
  output logic               cmd_o,
  output logic               sleep_o,
  output logic               busy_o,
  output logic               abort_o,
  output logic               err_o
);

  logic       req_s;
  logic       enter_start;
  mss_state_e state;

  mss_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sleep_req_i),
    .sync_o  (req_s)
  );

  mss_fsm #(
    .ENTRY_CYC (ENTRY_CYC),
    .EXIT_CYC  (EXIT_CYC),
    .RECOV_CYC (RECOV_CYC)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_s_i       (req_s),
    .state_o       (state),
    .enter_start_o (enter_start)
  );

  mss_guard #(
    .NUM_SEL (NUM_SEL)
  ) u_guard (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .enter_start_i (enter_start),
    .sel_i         (sel_i),
    .acc_pend_i    (acc_pend_i),
    .cmd_o         (cmd_o),
    .sleep_o       (sleep_o),
    .busy_o        (busy_o),
    .abort_o       (abort_o),
    .err_o         (err_o)
  );

endmodule

// File: rtl/mem_sleep_seq_chk.sv
`timescale 1ns/1ps
// Property checker, bound to the sequencer top.
module mem_sleep_seq_chk #(
  parameter int NUM_SEL   = 3,
  parameter int ENTRY_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SEL-1:0] sel_i,
  input logic               acc_pend_i,
  input logic               cmd_o,
  input logic               sleep_o,
  input logic               busy_o,
  input logic               abort_o,
  input logic               err_o
);

  // Length of the current run of busy-but-not-sleeping cycles.
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (busy_o && !sleep_o) begin
      if (run_q != 8'hFF) run_q <= run_q + 8'd1;
    end else begin
      run_q <= '0;
    end
  end

  a_r2_sleep_implies_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> busy_o);

  a_r3_entry_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> (run_q == 8'(ENTRY_CYC)));

  a_r4_recovery_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 8'(RECOV_CYC)));

  a_r5_cmd_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_o);

  a_r5_cmd_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (&sel_i)) |-> cmd_o);

  a_r6_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (&sel_i)) |=> err_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r7_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  a_r7_abort_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(acc_pend_i) && busy_o && !sleep_o));

endmodule

bind mem_sleep_seq mem_sleep_seq_chk #(
  .NUM_SEL   (NUM_SEL),
  .ENTRY_CYC (ENTRY_CYC),
  .RECOV_CYC (RECOV_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .acc_pend_i (acc_pend_i),
  .cmd_o      (cmd_o),
  .sleep_o    (sleep_o),
  .busy_o     (busy_o),
  .abort_o    (abort_o),
  .err_o      (err_o)
);

// File: tb/mem_sleep_seq_tb_top.sv
`timescale 1ns/1ps
module mem_sleep_seq_tb_top;

  localparam int NSEL = 3;
  localparam int NF   = 8;   // cycle index at which the request is dropped
  // Latencies in negedge steps from driving the request (derived from R2-R4 figures).
  localparam int BUSY_ON   = 3;
  localparam int SLEEP_ON  = 5;
  localparam int SLEEP_OFF = 5;
  localparam int BUSY_OFF  = 7;

  logic            clk;
  logic            rst_n;
  logic            req;
  logic [NSEL-1:0] sel;
  logic            pend;
  logic            cmd, slp, bsy, abrt, err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  mem_sleep_seq #(.NUM_SEL(NSEL)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sleep_req_i (req),
    .sel_i       (sel),
    .acc_pend_i  (pend),
    .cmd_o       (cmd),
    .sleep_o     (slp),
    .busy_o      (bsy),
    .abort_o     (abrt),
    .err_o       (err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req   = 1'b0;
    sel   = '0;
    pend  = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  function automatic bit exp_busy(input int k);
    return (k >= BUSY_ON) && (k < NF + BUSY_OFF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0; req = 1'b0; sel = '0; pend = 1'b0;
    step();
    chk("R1 sleep in reset", slp, 0);
    chk("R1 busy in reset", bsy, 0);
    do_reset();
    step();
    chk("R1 sleep", slp, 0);
    chk("R1 busy", bsy, 0);
    chk("R1 abort", abrt, 0);
    chk("R1 err", err, 0);

    // R5: every select pattern while awake
    for (int p = 0; p < (1 << NSEL); p++) begin
      sel = NSEL'(p);
      #2;
      chk("R5 awake pass", cmd, (p == (1 << NSEL) - 1) ? 1 : 0);
      step();
    end
    sel = '0;
    step();
    chk("R6 no err when awake", err, 0);

    // R2 R3 R4: full sleep cycle timeline
    do_reset();
    req = 1'b1;
    for (int k = 1; k <= NF + BUSY_OFF + 2; k++) begin
      step();
      if (k == NF) req = 1'b0;
      chk((k < SLEEP_ON) ? "R2 busy" : ((k < NF) ? "R3 busy" : "R4 busy"),
          bsy, exp_busy(k) ? 1 : 0);
      chk((k < NF) ? "R3 sleep" : "R4 sleep", slp,
          ((k >= SLEEP_ON) && (k < NF + SLEEP_OFF)) ? 1 : 0);
    end

    // R5 R6: one-cycle full selection swept across every offset
    for (int k = 0; k <= NF + BUSY_OFF + 1; k++) begin
      do_reset();
      req = 1'b1;
      for (int j = 0; j <= k; j++) begin
        if (j == NF) req = 1'b0;
        if (j == k) begin
          sel = '1;
          #2;
          chk("R5 gated select", cmd, exp_busy(k) ? 0 : 1);
        end else begin
          step();
        end
      end
      step();
      sel = '0;
      chk("R6 err after select", err, exp_busy(k) ? 1 : 0);
      step();
      step();
      chk("R6 err sticky", err, exp_busy(k) ? 1 : 0);
    end

    // R7: abort pulse with and without a pending access
    do_reset();
    pend = 1'b1;
    req  = 1'b1;
    step(); step();
    chk("R7 no early abort", abrt, 0);
    step();
    chk("R7 abort pulse", abrt, 1);
    step();
    chk("R7 abort ends", abrt, 0);
    do_reset();
    pend = 1'b0;
    req  = 1'b1;
    step(); step(); step();
    chk("R7 no abort idle", abrt, 0);

    // R8: one-cycle request pulse still completes entry
    do_reset();
    req = 1'b1;
    step();
    req = 1'b0;
    step(); step(); step();
    chk("R8 sleep not yet", slp, 0);
    step();
    chk("R8 sleep reached", slp, 1);
    step(); step();
    chk("R8 exit holds sleep", slp, 1);
    step();
    chk("R8 sleep released", slp, 0);
    step();
    chk("R8 recovery busy", bsy, 1);
    step();
    chk("R8 awake again", bsy, 0);

    // R9: request reasserted during exit
    do_reset();
    req = 1'b1;
    for (int k = 1; k <= NF + BUSY_OFF + 3; k++) begin
      step();
      if (k == NF) req = 1'b0;
      if (k == NF + 3) req = 1'b1;
      if (k == NF + BUSY_OFF)     chk("R9 one awake cycle", bsy, 0);
      if (k == NF + BUSY_OFF + 1) chk("R9 re-entry busy", bsy, 1);
      if (k == NF + BUSY_OFF + 2) chk("R9 entering", slp, 0);
      if (k == NF + BUSY_OFF + 3) chk("R9 asleep again", slp, 1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule